// File: doc/BRIEF.md
# Conditional Branch Condition Evaluator

This block decides whether a conditional relative branch is taken. It takes the four low bits of a branch opcode and five processor status flags: overflow, carry, zero, sign and parity. It returns one bit that is high when the branch should go. Bits 3..1 of the code pick one of eight flag tests. Bit 0 picks whether the branch goes when that test is true or when it is false.

The tests are not built as an eight-way selector. The block forms seven product terms. Each term matches a group of code patterns together with the flag state that group needs. The zero-flag term covers codes 01xx and the carry term covers codes 0x1x. The sign-differs-from-overflow term covers codes 11xx. These overlaps let seven terms serve eight tests. A single 7-input NOR merges the terms, and bit 0 of the code then sets the sense of the result.

A build-time parameter sets when the result appears. It can come straight from the logic in the same cycle, or one clock later from a register. The registered form lets the evaluator sit at the end of a pipeline stage.

Top module: `branch_cond_eval`

## Requirements
- R1: Codes 4'b0000 and 4'b0001 test overflow = 1.
- R2: Codes 4'b0010 and 4'b0011 test carry = 1.
- R3: Codes 4'b0100 and 4'b0101 test zero = 1.
- R4: Codes 4'b0110 and 4'b0111 test (carry = 1 or zero = 1).
- R5: Codes 4'b1000 and 4'b1001 test sign = 1.
- R6: Codes 4'b1010 and 4'b1011 test parity = 1.
- R7: Codes 4'b1100 and 4'b1101 test sign ≠ overflow.
- R8: Codes 4'b1110 and 4'b1111 test (zero = 1 or sign ≠ overflow).
- R9: Code bit 0 sets the sense of the test. An even code is taken when its test is true, and an odd code is taken when its test is false.
- R10: `take` is active high: 1 means take the branch, 0 means fall through.
- R11: With OUT_REG = 1, `take` gives the result for the code and flags sampled at the previous rising clock edge. While `rst_n` is low, `take` is 0.
- R12: With OUT_REG = 0, `take` follows the current code and flags in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| cc_code | input | 4 | Low four bits of the branch opcode |
| flag_ovf | input | 1 | Overflow flag |
| flag_cry | input | 1 | Carry flag |
| flag_zro | input | 1 | Zero flag |
| flag_sgn | input | 1 | Sign flag |
| flag_par | input | 1 | Parity flag |
| take | output | 1 | 1 when the branch is taken |

## Verification
The bench builds the block twice: once with OUT_REG = 1 and once with OUT_REG = 0. Both copies receive the same stimulus. It applies all 16 codes against all 32 flag combinations, which is 512 input cases and every input case there is. Each result is compared with a case table written in the bench. The pair of builds shows that the registered copy lags the combinational copy by exactly one edge, and that the registered copy holds 0 during reset.

// File: rtl/bce_pkg.sv
package bce_pkg;
    localparam int CC_W      = 4;
    localparam int NUM_TERMS = 7;

    typedef struct packed {
        logic ovf;
        logic cry;
        logic zro;
        logic sgn;
        logic par;
    } flags_t;

    typedef struct packed {
        logic take;
        logic armed;
    } out_st_t;
endpackage

// File: rtl/bce_terms.sv
module bce_terms
    import bce_pkg::*;
(
    input  logic [CC_W-1:0]      cc_code,
    input  flags_t               flags,
    output logic [NUM_TERMS-1:0] terms
);
    logic sne;

    // Each term is a NOR of code bits and complemented flags; 1 = pattern matched and flag holds
    always_comb begin
        sne      = flags.sgn ^ flags.ovf;
        // 000x : overflow
        terms[0] = ~(cc_code[3] | cc_code[2] | cc_code[1] | ~flags.ovf);
        // 0x1x : carry, shared by codes 001x and 011x
        terms[1] = ~(cc_code[3] | ~cc_code[1] | ~flags.cry);
        // 01xx : zero, shared by codes 010x and 011x
        terms[2] = ~(cc_code[3] | ~cc_code[2] | ~flags.zro);
        // 100x : sign
        terms[3] = ~(~cc_code[3] | cc_code[2] | cc_code[1] | ~flags.sgn);
        // 101x : parity
        terms[4] = ~(~cc_code[3] | cc_code[2] | ~cc_code[1] | ~flags.par);
        // 11xx : sign differs from overflow, shared by codes 110x and 111x
        terms[5] = ~(~cc_code[3] | ~cc_code[2] | ~sne);
        // 111x : zero
        terms[6] = ~(~cc_code[3] | ~cc_code[2] | ~cc_code[1] | ~flags.zro);
    end
endmodule

// File: rtl/bce_combine.sv
module bce_combine
    import bce_pkg::*;
(
    input  logic [NUM_TERMS-1:0] terms,
    input  logic                 sense_inv,
    output logic                 take_now
);
    logic nor_out;

    always_comb begin
        nor_out  = ~(|terms);          // 0 when the selected test holds
        take_now = ~(nor_out ^ sense_inv);
    end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import bce_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CC_W-1:0] cc_code,
    input  logic            flag_ovf,
    input  logic            flag_cry,
    input  logic            flag_zro,
    input  logic            flag_sgn,
    input  logic            flag_par,
    output logic            take
);
    flags_t                flags;
    logic [NUM_TERMS-1:0]  terms;
    logic                  take_now;
    out_st_t               st_d, st_q;

    assign flags = '{ovf: flag_ovf, cry: flag_cry, zro: flag_zro,
                      sgn: flag_sgn, par: flag_par};

    bce_terms u_terms (
        .cc_code (cc_code),
        .flags   (flags),
        .terms   (terms)
    );

    bce_combine u_combine (
        .terms     (terms),
        .sense_inv (cc_code[0]),
        .take_now  (take_now)
    );

    always_comb begin
        st_d       = st_q;
        st_d.take  = take_now;
        st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (OUT_REG) begin : g_reg
            assign take = st_q.take;

            AST_REG_LAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.armed |-> take == $past(take_now)); // R11
            AST_RESET_LOW: assert property (@(posedge clk)
                !rst_n |=> (!rst_n |-> !take)); // R11
        end else begin : g_comb
            assign take = take_now;
        end
    endgenerate

    AST_OVF_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        cc_code == 4'b0000 |-> take_now == flag_ovf); // R1
    AST_CRY_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        cc_code == 4'b0010 |-> take_now == flag_cry); // R2
    AST_ZRO_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        cc_code == 4'b0100 |-> take_now == flag_zro); // R3
    AST_BE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        cc_code == 4'b0110 |-> take_now == (flag_cry | flag_zro)); // R4
    AST_SGN_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        cc_code == 4'b1000 |-> take_now == flag_sgn); // R5
    AST_PAR_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        cc_code == 4'b1010 |-> take_now == flag_par); // R6
    AST_LT_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        cc_code == 4'b1100 |-> take_now == (flag_sgn != flag_ovf)); // R7
    AST_LE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        cc_code == 4'b1110 |-> take_now == (flag_zro | (flag_sgn != flag_ovf))); // R8
    AST_ODD_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        cc_code == 4'b0001 |-> take_now == !flag_ovf); // R9
    AST_TERMS_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(terms) <= 2); // R10
endmodule

// File: tb/test_branch_cond_eval.sv
module test_branch_cond_eval;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cc_code = '0;
    logic [4:0] fl = '0;  // {ovf, cry, zro, sgn, par}
    logic       take_reg, take_cmb;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    branch_cond_eval #(.OUT_REG(1'b1)) i_branch_cond_eval (
        .clk(clk), .rst_n(rst_n), .cc_code(cc_code),
        .flag_ovf(fl[4]), .flag_cry(fl[3]), .flag_zro(fl[2]),
        .flag_sgn(fl[1]), .flag_par(fl[0]), .take(take_reg));

    branch_cond_eval #(.OUT_REG(1'b0)) i_branch_cond_eval_comb (
        .clk(clk), .rst_n(rst_n), .cc_code(cc_code),
        .flag_ovf(fl[4]), .flag_cry(fl[3]), .flag_zro(fl[2]),
        .flag_sgn(fl[1]), .flag_par(fl[0]), .take(take_cmb));

    function automatic logic ref_take(input logic [3:0] c, input logic [4:0] f);
        logic o, cy, z, s, p, t;
        {o, cy, z, s, p} = f;
        case (c[3:1])
            3'd0: t = o;                  // R1
            3'd1: t = cy;                 // R2
            3'd2: t = z;                  // R3
            3'd3: t = cy | z;             // R4
            3'd4: t = s;                  // R5
            3'd5: t = p;                  // R6
            3'd6: t = s != o;             // R7
            default: t = z | (s != o);    // R8
        endcase
        return c[0] ? !t : t;             // R9, R10
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        if (c[0]) return "R9";
        case (c[3:1])
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp,
                         input logic [3:0] c, input logic [4:0] f);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s code=%b flags=%b actual=%b expected=%b", req, c, f, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset holds the registered output low, even when the test is true
        cc_code = 4'b0001; fl = 5'b00000;   // code 0001 with no overflow: comb says take
        repeat (3) @(posedge clk);
        #1;
        check("R11", take_reg, 1'b0, cc_code, fl);
        check("R12", take_cmb, 1'b1, cc_code, fl);
        @(negedge clk) rst_n = 1'b1;

        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 32; f++) begin
                @(negedge clk);
                cc_code = 4'(c);
                fl      = 5'(f);
                #1;
                // R12: combinational copy follows input in the same cycle
                check(tag_of(cc_code), take_cmb, ref_take(cc_code, fl), cc_code, fl);
                @(posedge clk);
                #1;
                // R11: registered copy shows the value sampled at this edge
                check("R11", take_reg, ref_take(cc_code, fl), cc_code, fl);
            end
        end

        // R11: registered output holds between edges while inputs change
        @(negedge clk);
        cc_code = 4'b0100; fl = 5'b00100;   // zero set: take = 1
        @(posedge clk); #1;
        cc_code = 4'b0101;                  // comb flips to 0, register holds
        #1;
        check("R11", take_reg, 1'b1, 4'b0100, fl);
        check("R12", take_cmb, 1'b0, cc_code, fl);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule